// File: doc/BRIEF.md
# Serial SAR Converter Readout Controller

This block is the host side of a link to one 18-bit successive-approximation converter. The link has three wires and no busy flag, and the converter's data-in pin is strapped high. A single convert line serves two jobs. Its rising edge starts a conversion, and while it is low it selects the converter for readout. The converter keeps converting no matter what this line does after the start. The host must keep the line high for the worst-case conversion time so that the converter never reports busy.

When the controller is idle and sees a start request, it raises the convert line and holds it for a fixed number of system-clock cycles. It then drops the line. At that moment the converter already drives the most significant bit. The controller samples that bit first and then issues 18 serial clock pulses. The converter moves to its next bit on each falling edge. The controller samples each bit just before the rising edge of the next pulse. After the 18th falling edge the assembled word goes to a parallel output, marked by a valid strobe one system clock wide. The convert-high time, the minimum convert-high width and the serial clock half period are parameters counted in system-clock cycles.

Top module: `sar_rd_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, the convert line and serial clock are low, ready is high, the valid strobe is low and the parallel word is zero.
- R2: A start request sampled while ready is high drives the convert line high on the following cycle, and ready goes low on that same cycle.
- R3: The convert line stays high for exactly HOLD system-clock cycles, where HOLD is the larger of CONV_CYC and MIN_HI (36 with default parameters).
- R4: The serial clock is low when the convert line falls. Exactly 18 serial clock pulses follow before the result is reported.
- R5: Each serial clock high phase and each low phase that ends in a rising edge lasts exactly HALF_DIV system-clock cycles. The first rising edge comes HALF_DIV cycles after the convert line falls.
- R6: The data line is sampled once before each rising serial clock edge. The first sample is the bit present right after the convert line falls and lands in bit 17 of the parallel word. Later samples fill the lower bits in order, down to bit 0.
- R7: The valid strobe goes high for exactly one cycle, on the cycle the 18th falling edge appears (2*HALF_DIV*18 cycles after the convert line falls). The parallel word changes only on that cycle.
- R8: A start request sampled while ready is low has no effect. The convert line does not rise again, and the transaction in progress completes with its own data.
- R9: The serial clock never goes high while the convert line is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request for one conversion and readout |
| ready | output | 1 | High while the controller is idle |
| cnv | output | 1 | Convert start and chip select line to the converter |
| sclk | output | 1 | Serial clock to the converter |
| sdo | input | 1 | Serial data from the converter |
| data_out | output | 18 | Last assembled conversion result |
| data_vld | output | 1 | One-cycle strobe marking a new data_out |

## Verification
The bench goes after the most significant bit, which is already on the line before any clock. Words with only bit 17 or only bit 0 set would come out shifted by one place in a design that waits for a clock edge before its first sample, or that samples after the falling edge. It also counts the convert-high cycles and the serial pulses on every transfer, because an off-by-one end count would give 17 or 19 pulses or trim the worst-case conversion window. Start requests during conversion and during readout check that a design which restarts early neither gives a second rising edge on the convert line nor corrupts the word in flight.

// File: rtl/sar_rd_ctrl.sv
module sar_rd_ctrl #(
  parameter int DATA_W   = 18,
  parameter int CONV_CYC = 36,
  parameter int MIN_HI   = 2,
  parameter int HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              ready,
  output logic              cnv,
  output logic              sclk,
  input  logic              sdo,
  output logic [DATA_W-1:0] data_out,
  output logic              data_vld
);
  localparam int HOLD = (CONV_CYC > MIN_HI) ? CONV_CYC : MIN_HI;
  localparam int TMAX = (HOLD > HALF_DIV) ? HOLD : HALF_DIV;
  localparam int CW   = $clog2(TMAX + 1);
  localparam int BW   = $clog2(DATA_W + 1);

  typedef enum logic [1:0] {S_IDLE, S_CONV, S_READ} state_t;

  state_t            st;
  logic [CW-1:0]     tmr;
  logic [BW-1:0]     bitn;
  logic              cnv_r, sclk_r, vld_r;
  logic [DATA_W-1:0] shreg, dout_r;

  wire tmr_end = (st == S_CONV) ? (tmr == CW'(HOLD - 1)) : (tmr == CW'(HALF_DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      tmr    <= '0;
      bitn   <= '0;
      cnv_r  <= 1'b0;
      sclk_r <= 1'b0;
      vld_r  <= 1'b0;
      shreg  <= '0;
      dout_r <= '0;
    end else begin
      vld_r <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st    <= S_CONV;
          cnv_r <= 1'b1;
          tmr   <= '0;
        end
        S_CONV: if (tmr_end) begin
          st    <= S_READ;
          cnv_r <= 1'b0;
          tmr   <= '0;
          bitn  <= '0;
        end else begin
          tmr <= tmr + 1'b1;
        end
        S_READ: if (tmr_end) begin
          tmr <= '0;
          if (!sclk_r) begin
            sclk_r <= 1'b1;
            shreg  <= {shreg[DATA_W-2:0], sdo};
          end else begin
            sclk_r <= 1'b0;
            if (bitn == BW'(DATA_W - 1)) begin
              st     <= S_IDLE;
              dout_r <= shreg;
              vld_r  <= 1'b1;
            end else begin
              bitn <= bitn + 1'b1;
            end
          end
        end else begin
          tmr <= tmr + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign ready    = (st == S_IDLE);
  assign cnv      = cnv_r;
  assign sclk     = sclk_r;
  assign data_out = dout_r;
  assign data_vld = vld_r;
endmodule

// File: rtl/sar_rd_ctrl_chk.sv
module sar_rd_ctrl_chk #(
  parameter int DATA_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              ready,
  input logic              cnv,
  input logic              sclk,
  input logic [DATA_W-1:0] data_out,
  input logic              data_vld
);
  p_start_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && start) |=> (cnv && !ready));

  p_fall_sclk_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cnv) |-> !sclk);

  p_vld_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    data_vld |=> !data_vld);

  p_word_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !data_vld |-> $stable(data_out));

  p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && !cnv) |=> !cnv);

  p_sclk_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnv |-> !sclk);
endmodule

bind sar_rd_ctrl sar_rd_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .ready(ready), .cnv(cnv),
  .sclk(sclk), .data_out(data_out), .data_vld(data_vld)
);

// File: tb/test_sar_rd_ctrl.sv
module test_sar_rd_ctrl;
  localparam int W    = 18;
  localparam int HOLD = 36;
  localparam int HALF = 2;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, sdo = 1'b0;
  logic ready, cnv, sclk, data_vld;
  logic [W-1:0] data_out;

  int vectors = 0, errors = 0, cycles = 0;
  logic [W-1:0] next_word = '0, word_lat = '0;
  int falls = 0;

  always #10 clk = ~clk;

  sar_rd_ctrl #(.DATA_W(W), .CONV_CYC(HOLD), .MIN_HI(2), .HALF_DIV(HALF)) i_sar_rd_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .ready(ready), .cnv(cnv),
    .sclk(sclk), .sdo(sdo), .data_out(data_out), .data_vld(data_vld)
  );

  // converter model
  always @(posedge cnv) begin word_lat = next_word; sdo = 1'b0; end
  always @(negedge cnv) begin falls = 0; sdo = word_lat[W-1]; end
  always @(negedge sclk) begin
    falls = falls + 1;
    sdo = (falls < W) ? word_lat[W-1-falls] : 1'b0;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
      finish_run();
    end
  end

  task automatic t_reset();
    @(negedge clk);
    chk(cnv == 0 && sclk == 0 && ready == 1 && data_vld == 0 && data_out == 0,
        "R1 reset state", {cnv, sclk, ready, data_vld}, 4'b0010);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cnv == 0 && ready == 1 && data_out == 0, "R1 after reset", {cnv, ready}, 2'b01);
  endtask

  // one full transfer; poke_conv / poke_read issue a stray start mid-transfer
  task automatic t_transfer(input logic [W-1:0] word, input bit poke_conv, input bit poke_read);
    int hi, cyc, pulses, run, badph, rises;
    logic prev;
    next_word = word;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(cnv == 1 && ready == 0, "R2 start accepted", {cnv, ready}, 2'b10);
    hi = 0;
    while (cnv && hi < 1000) begin
      if (sclk) badph++;
      if (poke_conv && hi == 5) start = 1'b1;
      if (poke_conv && hi == 6) start = 1'b0;
      hi++;
      @(negedge clk);
    end
    chk(hi == HOLD, "R3 convert high cycles", hi, HOLD);
    chk(badph == 0, "R9 sclk quiet in conversion", badph, 0);
    chk(sclk == 0, "R4 sclk low at convert fall", sclk, 0);
    cyc = 1; pulses = 0; run = 1; badph = 0; rises = 0; prev = 1'b0;
    while (!data_vld && cyc < 1000) begin
      if (poke_read && cyc == 20) start = 1'b1;
      if (poke_read && cyc == 21) start = 1'b0;
      @(negedge clk);
      cyc++;
      if (cnv) rises++;
      if (sclk != prev) begin
        if (run != HALF) badph++;
        if (sclk) pulses++;
        run = 1;
      end else run++;
      prev = sclk;
    end
    chk(cyc == 2*HALF*W + 1, "R7 valid timing", cyc, 2*HALF*W + 1);
    chk(pulses == W, "R4 pulse count", pulses, W);
    chk(badph == 0, "R5 phase widths", badph, 0);
    chk(data_out == word, "R6 assembled word", data_out, word);
    if (poke_conv || poke_read)
      chk(rises == 0, "R8 stray start ignored", rises, 0);
    @(negedge clk);
    chk(data_vld == 0 && data_out == word && ready == 1, "R7 single strobe and hold",
        {data_vld, ready}, 2'b01);
  endtask

  task automatic t_idle_hold();
    logic [W-1:0] held;
    held = data_out;
    repeat (10) @(negedge clk);
    chk(data_out == held && data_vld == 0 && cnv == 0, "R7 word stable while idle", data_out, held);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_transfer(18'h2AAAA, 0, 0);
    t_transfer(18'h15555, 0, 0);
    t_transfer(18'h20000, 0, 0);
    t_transfer(18'h00001, 0, 0);
    t_transfer(18'h3FFFF, 0, 0);
    t_transfer(18'h00000, 0, 0);
    t_idle_hold();
    t_transfer(18'h1C3A5, 1, 0);
    t_transfer(18'h0F0F1, 0, 1);
    finish_run();
  end
endmodule